// File: doc/BRIEF.md
# Coprocessor Host Command and Save-Status Registers

This block is the coprocessor-side logic behind two locations of its host-visible register window. The host writes a command word at one offset to either acknowledge an exception that the coprocessor has asked for, or to kill the coprocessor instruction that is running. Only the two low bits of that word carry meaning.

The host reads a 16-bit status word at a second offset. That read also tells the coprocessor core to begin saving its internal state. The word returned is whatever format code the core is presenting at the time of the read.

Each accepted command becomes a single-clock pulse toward the core. The block also keeps a small view of the core's instruction activity. That view has a busy flag and a pending-exception flag. An abort clears both.

Top module: `copro_ifc_regs`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all command pulses, `exc_pending` and `insn_busy` are 0.
- R2: A write to byte offset 0x02 with bits [1:0] = 2'b10 gives one `cmd_ack` pulse in the cycle after the write cycle, and clears `exc_pending`. From the exception-wait state, the tracking returns to idle.
- R3: A write to offset 0x02 with bits [1:0] = 2'b01 gives one `cmd_abort` pulse in the cycle after the write cycle. In that same cycle `exc_pending` and `insn_busy` read 0.
- R4: A write to offset 0x02 with bits [1:0] = 2'b11 is an abort only: `cmd_abort` pulses and `cmd_ack` stays 0.
- R5: Bits [15:2] of a command write have no effect. 0xFFFE acts as an acknowledge, and 0xFFFC or 0x0000 produce no pulse and leave the flags unchanged.
- R6: While the host reads offset 0x04, `host_rdata` equals `core_fmt` in the same cycle, following any change of `core_fmt`.
- R7: A read of offset 0x04 gives exactly one `cmd_save` pulse, in the cycle after the first read cycle. This holds however many cycles the read strobe stays high.
- R8: A read of offset 0x02 returns 0x0000 and produces no pulse.
- R9: Writes and reads at any other offset, odd offsets included, return 0x0000 and produce no pulse. They leave `exc_pending` and `insn_busy` unchanged.
- R10: The cycle after an instruction-start pulse `core_go` in the idle state, `insn_busy` is 1. It is 0 again the cycle after `core_done`. The cycle after `core_exc_req`, `exc_pending` is 1 and `insn_busy` is 1.
- R11: An abort write overrides `core_go` and `core_exc_req` arriving in the same cycle. Afterwards `insn_busy` and `exc_pending` are both 0.
- R12: With `host_rd` low, `host_rdata` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Byte offset within the register window |
| host_rd | input | 1 | Read strobe, one access per high period |
| host_wr | input | 1 | Write strobe, one access per high cycle |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, combinational from address and strobe |
| core_fmt | input | 16 | Status/format word supplied by the core |
| core_go | input | 1 | Core pulse: an instruction has started |
| core_done | input | 1 | Core pulse: the instruction has completed |
| core_exc_req | input | 1 | Core pulse: the core requests exception handling |
| cmd_ack | output | 1 | One-clock exception-acknowledge pulse to the core |
| cmd_abort | output | 1 | One-clock abort pulse to the core |
| cmd_save | output | 1 | One-clock save-start pulse to the core |
| exc_pending | output | 1 | An exception request awaits acknowledgement |
| insn_busy | output | 1 | The tracking state is not idle |

## Verification
Read data is combinational, so it is sampled a fraction of a nanosecond after the bench drives address and strobe, within the same cycle. Command pulses and the two flags are registered once. They are sampled at the falling edge that follows the rising edge where the access was taken, and the absence of a pulse is checked again one cycle later. The checks on a held save read count `cmd_save` pulses across every cycle of the hold. The reset checks wait the two synchronizer cycles before the bench issues any access.

// File: rtl/copro_ifc_pkg.sv
package copro_ifc_pkg;

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_BUSY = 2'd1,
    TRK_EXC  = 2'd2
  } trk_state_e;

  localparam int KILL_BIT = 0;
  localparam int ACK_BIT  = 1;

  typedef struct packed {
    logic ack;
    logic abort;
  } cmd_bits_t;

endpackage

// File: rtl/copro_ifc_rst_sync.sv
module copro_ifc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/copro_ifc_decode.sv
module copro_ifc_decode #(
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFS = 2,
  parameter int SAVE_OFS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              ctrl_wr,
  output logic              ctrl_rd,
  output logic              save_rd
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_OFS);
  localparam int NSEL = 2;

  logic [NSEL-1:0] hit;
  logic            aligned;

  assign aligned = ~addr[0];

  genvar gi;
  generate
    for (gi = 0; gi < NSEL; gi++) begin : g_hit
      if (gi == 0) begin : g_ctrl
        assign hit[gi] = aligned && (addr == CTRL_A);
      end else begin : g_save
        assign hit[gi] = aligned && (addr == SAVE_A);
      end
    end
  endgenerate

  always_comb begin
    ctrl_wr = wr & hit[0];
    ctrl_rd = rd & hit[0];
    save_rd = rd & hit[1];
  end
endmodule

// File: rtl/copro_ifc_ctrl.sv
module copro_ifc_ctrl
  import copro_ifc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [1:0] wbits,
  input  logic       core_go,
  input  logic       core_done,
  input  logic       core_exc_req,
  output logic       ack_p,
  output logic       abort_p,
  output logic       exc_pending,
  output logic       insn_busy
);
  trk_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       ack_q, ack_d;
  logic       abort_q, abort_d;
  logic       do_abort, do_ack;

  always_comb begin
    do_abort = ctrl_wr && wbits[KILL_BIT];
    do_ack   = ctrl_wr && wbits[ACK_BIT] && !wbits[KILL_BIT];
  end

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    ack_d   = do_ack;
    abort_d = do_abort;
    if (do_abort) begin
      state_d = TRK_IDLE;
      pend_d  = 1'b0;
    end else begin
      if (do_ack) begin
        pend_d = 1'b0;
        if (state_q == TRK_EXC) state_d = TRK_IDLE;
      end
      case (state_q)
        TRK_IDLE: if (core_go)   state_d = TRK_BUSY;
        TRK_BUSY: if (core_done) state_d = TRK_IDLE;
        default:  ;
      endcase
      if (core_exc_req) begin
        pend_d  = 1'b1;
        state_d = TRK_EXC;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TRK_IDLE;
      pend_q  <= 1'b0;
      ack_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      ack_q   <= ack_d;
      abort_q <= abort_d;
    end
  end

  assign ack_p       = ack_q;
  assign abort_p     = abort_q;
  assign exc_pending = pend_q;
  assign insn_busy   = (state_q != TRK_IDLE);
endmodule

// File: rtl/copro_ifc_save.sv
module copro_ifc_save #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_rd,
  input  logic [DATA_W-1:0] fmt,
  output logic [DATA_W-1:0] rd_word,
  output logic              save_p
);
  logic prev_q, prev_d;
  logic pulse_q, pulse_d;

  always_comb begin
    prev_d  = save_rd;
    pulse_d = save_rd && !prev_q;
    rd_word = save_rd ? fmt : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      pulse_q <= pulse_d;
    end
  end

  assign save_p = pulse_q;
endmodule

// File: rtl/copro_ifc_regs.sv
module copro_ifc_regs
  import copro_ifc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int CTRL_OFS = 2,
  parameter int SAVE_OFS = 4,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] core_fmt,
  input  logic              core_go,
  input  logic              core_done,
  input  logic              core_exc_req,
  output logic              cmd_ack,
  output logic              cmd_abort,
  output logic              cmd_save,
  output logic              exc_pending,
  output logic              insn_busy
);
  logic       rst_n_s;
  logic       ctrl_wr, ctrl_rd, save_rd;
  logic [1:0] wbits;
  logic       unused_hi;
  logic [DATA_W-1:0] save_word;

  copro_ifc_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  copro_ifc_decode #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .SAVE_OFS(SAVE_OFS)) u_dec (
    .addr(host_addr), .rd(host_rd), .wr(host_wr),
    .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd), .save_rd(save_rd)
  );

  assign wbits     = host_wdata[1:0];
  assign unused_hi = ^{host_wdata[DATA_W-1:2], ctrl_rd};

  copro_ifc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .ctrl_wr(ctrl_wr), .wbits(wbits),
    .core_go(core_go), .core_done(core_done), .core_exc_req(core_exc_req),
    .ack_p(cmd_ack), .abort_p(cmd_abort),
    .exc_pending(exc_pending), .insn_busy(insn_busy)
  );

  copro_ifc_save #(.DATA_W(DATA_W)) u_save (
    .clk(clk), .rst_n(rst_n_s), .save_rd(save_rd), .fmt(core_fmt),
    .rd_word(save_word), .save_p(cmd_save)
  );

  // Control location reads as zero; only the save word is ever driven out.
  assign host_rdata = save_word;
endmodule

// File: rtl/copro_ifc_regs_chk.sv
module copro_ifc_regs_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int CTRL_OFS = 2,
  parameter int SAVE_OFS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rd,
  input logic              host_wr,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic [DATA_W-1:0] core_fmt,
  input logic              cmd_ack,
  input logic              cmd_abort,
  input logic              cmd_save,
  input logic              exc_pending,
  input logic              insn_busy
);
  localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] SA = ADDR_W'(SAVE_OFS);

  AST_ACK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> $past(host_wr && host_addr == CA && host_wdata[1:0] == 2'b10)); // R2
  AST_ABORT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |-> $past(host_wr && host_addr == CA && host_wdata[0])); // R3
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |-> (!exc_pending && !insn_busy)); // R11
  AST_NO_ACK_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ack && cmd_abort)); // R4
  AST_SAVE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == SA) |-> host_rdata == core_fmt); // R6
  AST_SAVE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_save |-> $past(host_rd && host_addr == SA)); // R7
  AST_SAVE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_save |=> !cmd_save); // R7
  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == CA) |-> host_rdata == '0); // R8
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |-> host_rdata == '0); // R12
endmodule

bind copro_ifc_regs copro_ifc_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFS(CTRL_OFS), .SAVE_OFS(SAVE_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
  .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .core_fmt(core_fmt), .cmd_ack(cmd_ack), .cmd_abort(cmd_abort),
  .cmd_save(cmd_save), .exc_pending(exc_pending), .insn_busy(insn_busy)
);

// File: tb/copro_ifc_regs_test.sv
`timescale 1ns/1ps
module copro_ifc_regs_test;
  logic        clk;
  logic        rst_n;
  logic [7:0]  host_addr;
  logic        host_rd, host_wr;
  logic [15:0] host_wdata, host_rdata, core_fmt;
  logic        core_go, core_done, core_exc_req;
  logic        cmd_ack, cmd_abort, cmd_save, exc_pending, insn_busy;

  int total = 0;
  int bad   = 0;

  copro_ifc_regs uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_fmt(core_fmt), .core_go(core_go), .core_done(core_done),
    .core_exc_req(core_exc_req), .cmd_ack(cmd_ack), .cmd_abort(cmd_abort),
    .cmd_save(cmd_save), .exc_pending(exc_pending), .insn_busy(insn_busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulses(input string req, input logic a, input logic k, input logic s);
    chk({req, " cmd_ack"},   {15'd0, cmd_ack},   {15'd0, a});
    chk({req, " cmd_abort"}, {15'd0, cmd_abort}, {15'd0, k});
    chk({req, " cmd_save"},  {15'd0, cmd_save},  {15'd0, s});
  endtask

  // One write cycle; returns at the falling edge after the capturing rising edge.
  task automatic host_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = 16'h0000;
  endtask

  task automatic core_pulse(input logic g, input logic dn, input logic e);
    @(negedge clk);
    core_go = g; core_done = dn; core_exc_req = e;
    @(negedge clk);
    core_go = 1'b0; core_done = 1'b0; core_exc_req = 1'b0;
  endtask

  task automatic idle_cycle;
    @(negedge clk);
    pulses("idle", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    host_addr = 8'h00; host_rd = 1'b0; host_wr = 1'b0; host_wdata = 16'h0;
    core_fmt = 16'h0; core_go = 1'b0; core_done = 1'b0; core_exc_req = 1'b0;
    repeat (4) @(negedge clk);
    pulses("R1 in reset", 1'b0, 1'b0, 1'b0);
    chk("R1 exc_pending", {15'd0, exc_pending}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    pulses("R1 after release", 1'b0, 1'b0, 1'b0);
    chk("R1 insn_busy", {15'd0, insn_busy}, 16'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_track;
    core_pulse(1'b1, 1'b0, 1'b0);
    chk("R10 busy after go", {15'd0, insn_busy}, 16'd1);
    core_pulse(1'b0, 1'b1, 1'b0);
    chk("R10 idle after done", {15'd0, insn_busy}, 16'd0);
    core_pulse(1'b0, 1'b0, 1'b1);
    chk("R10 pending after req", {15'd0, exc_pending}, 16'd1);
    chk("R10 busy during exc", {15'd0, insn_busy}, 16'd1);
  endtask

  task automatic t_ack;
    host_write(8'h02, 16'h0002);
    pulses("R2 ack write", 1'b1, 1'b0, 1'b0);
    chk("R2 pending cleared", {15'd0, exc_pending}, 16'd0);
    chk("R2 back to idle", {15'd0, insn_busy}, 16'd0);
    idle_cycle();
  endtask

  task automatic t_abort;
    core_pulse(1'b1, 1'b0, 1'b0);
    core_pulse(1'b0, 1'b0, 1'b1);
    host_write(8'h02, 16'h0001);
    pulses("R3 abort write", 1'b0, 1'b1, 1'b0);
    chk("R3 busy cleared", {15'd0, insn_busy}, 16'd0);
    chk("R3 pending cleared", {15'd0, exc_pending}, 16'd0);
    idle_cycle();
  endtask

  task automatic t_both;
    core_pulse(1'b0, 1'b0, 1'b1);
    host_write(8'h02, 16'h0003);
    pulses("R4 both bits", 1'b0, 1'b1, 1'b0);
    chk("R4 pending cleared", {15'd0, exc_pending}, 16'd0);
  endtask

  task automatic t_upper;
    core_pulse(1'b0, 1'b0, 1'b1);
    host_write(8'h02, 16'hFFFC);
    pulses("R5 upper only", 1'b0, 1'b0, 1'b0);
    chk("R5 pending kept", {15'd0, exc_pending}, 16'd1);
    host_write(8'h02, 16'h0000);
    pulses("R5 zero word", 1'b0, 1'b0, 1'b0);
    chk("R5 busy kept", {15'd0, insn_busy}, 16'd1);
    host_write(8'h02, 16'hFFFE);
    pulses("R5 ack with upper bits", 1'b1, 1'b0, 1'b0);
    chk("R5 pending cleared", {15'd0, exc_pending}, 16'd0);
  endtask

  task automatic t_save;
    int n;
    n = 0;
    @(negedge clk);
    core_fmt = 16'hA5C3; host_addr = 8'h04; host_rd = 1'b1;
    #0.5;
    chk("R6 save word", host_rdata, 16'hA5C3);
    chk("R7 no pulse in read cycle", {15'd0, cmd_save}, 16'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (cmd_save) n++;
      if (i == 1) begin
        core_fmt = 16'h3C5A;
        #0.5;
        chk("R6 follows core_fmt", host_rdata, 16'h3C5A);
      end
    end
    chk("R7 single save pulse", n[15:0], 16'd1);
    host_rd = 1'b0;
    #0.5;
    chk("R12 rdata idle", host_rdata, 16'h0000);
    @(negedge clk);
    chk("R7 none after release", {15'd0, cmd_save}, 16'd0);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk("R7 new access new pulse", {15'd0, cmd_save}, 16'd1);
  endtask

  task automatic t_ctrl_read;
    @(negedge clk);
    core_fmt = 16'hFFFF; host_addr = 8'h02; host_rd = 1'b1;
    #0.5;
    chk("R8 ctrl read zero", host_rdata, 16'h0000);
    @(negedge clk);
    host_rd = 1'b0;
    pulses("R8 ctrl read", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_other;
    core_pulse(1'b0, 1'b0, 1'b1);
    host_write(8'h06, 16'h0001);
    pulses("R9 write 0x06", 1'b0, 1'b0, 1'b0);
    host_write(8'h03, 16'h0003);
    pulses("R9 write 0x03", 1'b0, 1'b0, 1'b0);
    chk("R9 pending kept", {15'd0, exc_pending}, 16'd1);
    chk("R9 busy kept", {15'd0, insn_busy}, 16'd1);
    @(negedge clk);
    host_addr = 8'h05; host_rd = 1'b1;
    #0.5;
    chk("R9 read 0x05", host_rdata, 16'h0000);
    @(negedge clk);
    host_rd = 1'b0;
    pulses("R9 read 0x05", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_override;
    host_write(8'h02, 16'h0001);
    @(negedge clk);
    core_go = 1'b1; core_exc_req = 1'b1;
    host_addr = 8'h02; host_wdata = 16'h0001; host_wr = 1'b1;
    @(negedge clk);
    core_go = 1'b0; core_exc_req = 1'b0; host_wr = 1'b0;
    chk("R11 busy after override", {15'd0, insn_busy}, 16'd0);
    chk("R11 pending after override", {15'd0, exc_pending}, 16'd0);
    chk("R11 abort pulse", {15'd0, cmd_abort}, 16'd1);
  endtask

  initial begin
    #(4 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_track();
    t_ack();
    t_abort();
    t_both();
    t_upper();
    t_save();
    t_ctrl_read();
    t_other();
    t_override();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule